// File: doc/BRIEF.md
# Seven-Port Priority Memory Request Arbiter

This block collects memory requests from seven independent master ports and feeds them, one at a time, into a single downstream command channel that uses valid/ready handshakes. Each port gives an address, a burst size flag (16 or 32 bytes), a read/write flag, per-byte write enables and a 4-bit priority. The port may change the priority at any time. Whenever the arbiter is idle, it grants the eligible requesting port with the largest priority value. When several ports share that value, a rotating pointer breaks the tie.

A write burst is moved beat by beat from the port into a five-entry buffer. Each entry holds up to 32 bytes of data plus the byte enables. The buffer then drains downstream in the order the bursts were accepted. A read goes downstream as one command transfer; the read data return path lies outside this block. A read whose 32-byte line matches a write that is still buffered is held until that write has fully drained. The DRAM timing engine, refresh and the physical interface live elsewhere.

Top module: `mem_req_arbiter`

## Requirements
- R1: At most one port sees `req_ready_o` high in any cycle.
- R2: When idle, the arbiter grants the requesting eligible port with the numerically largest `req_prio_i` value seen in the arbitration cycle. A write is eligible only while the buffer has a free entry.
- R3: Among eligible ports that share the largest priority, the first one found scanning upward (wrapping from port 6 to port 0) from the port after the previous winner is granted. After reset the scan starts at port 0.
- R4: A burst with `req_long_i`=0 is 16 bytes and takes 2 beats of 64 bits. With `req_long_i`=1 it is 32 bytes and takes 4 beats. On the downstream side, `dn_last_o` marks the final write beat.
- R5: A grant is held until the whole burst of the granted port has been handshaken. No other port is served in between.
- R6: Write data and byte enables appear downstream unchanged, beat for beat, in the order the port supplied them.
- R7: The write buffer holds five bursts. With the downstream channel stalled, exactly five write bursts are accepted and further writes wait.
- R8: Buffered write bursts leave downstream in the order they were accepted, each tagged with its port number on `dn_port_o` and its address.
- R9: A read whose address bits [31:5] match a write still held in the buffer is not accepted until that write has completely drained.
- R10: A read appears downstream as a single transfer with `dn_write_o`=0 and `dn_last_o`=1, carrying the read's address, burst size and port number.
- R11: While `dn_valid_o` is high and `dn_ready_i` is low, the downstream valid, address, direction and data stay unchanged into the next cycle.
- R12: After reset, no port is ready and `dn_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 7 | Per-port request / beat valid |
| req_ready_o | output | 7 | Per-port beat accepted |
| req_write_i | input | 7 | Per-port direction, 1 = write |
| req_long_i | input | 7 | Per-port burst size, 1 = 32 bytes, 0 = 16 bytes |
| req_prio_i | input | 7x4 | Per-port dynamic priority |
| req_addr_i | input | 7x32 | Per-port burst address |
| req_wdata_i | input | 7x64 | Per-port write beat data |
| req_be_i | input | 7x8 | Per-port write beat byte enables |
| dn_valid_o | output | 1 | Downstream transfer valid |
| dn_ready_i | input | 1 | Downstream transfer accepted |
| dn_write_o | output | 1 | Transfer is a write beat |
| dn_long_o | output | 1 | Burst is 32 bytes |
| dn_port_o | output | 3 | Originating port |
| dn_addr_o | output | 32 | Burst address |
| dn_wdata_o | output | 64 | Write beat data |
| dn_be_o | output | 8 | Write beat byte enables |
| dn_last_o | output | 1 | Final transfer of the burst |

## Verification
The bench first runs all-read sets with distinct priorities. These show whether the largest value wins. It then runs sets where every priority is equal, twice in a row, to show whether the tie pointer really rotates and carries over between rounds. Next come a sweep that puts one port at the top priority while the rest tie at low values, and all-write sets with random-looking data. These separate ordering faults from data and byte-enable corruption. Finally, a stalled downstream channel exposes the five-entry limit, and a read that targets the line of a buffered write tests the hazard stall.

// File: rtl/mem_arb_pkg.sv
`timescale 1ns/1ps
package mem_arb_pkg;
  localparam int NPORT    = 7;
  localparam int PRIO_W   = 4;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 64;
  localparam int WB_DEPTH = 5;
  localparam int LINE_B   = 32;
  localparam int LINE_LSB = $clog2(LINE_B);
endpackage

// File: rtl/arb_prio_pick.sv
`timescale 1ns/1ps
module arb_prio_pick #(
  parameter int N  = 7,
  parameter int PW = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]         cand_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  input  logic [IW-1:0]        ptr_i,
  output logic                 found_o,
  output logic [IW-1:0]        win_o
);
  logic [PW-1:0] top;
  logic          hit;
  int            idx;

  always_comb begin
    top     = '0;
    found_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!found_o || prio_i[i] > top)) begin
        top     = prio_i[i];
        found_o = 1'b1;
      end
    end
    // rotating scan among the ports at the top value
    win_o = '0;
    hit   = 1'b0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_i) + k;
      if (idx >= N) idx = idx - N;
      if (!hit && cand_i[idx] && prio_i[idx] == top) begin
        hit   = 1'b1;
        win_o = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/arb_wr_buf.sv
`timescale 1ns/1ps
module arb_wr_buf #(
  parameter int DEPTH    = 5,
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int IW       = 3,
  parameter int BEATS    = 4,
  parameter int LINE_LSB = 5,
  parameter int BTW      = $clog2(BEATS),
  parameter int DPW      = $clog2(DEPTH),
  parameter int BW       = DW / 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  output logic                   full_o,
  input  logic                   fill_en_i,
  input  logic [BTW-1:0]         fill_beat_i,
  input  logic [DW-1:0]          fill_data_i,
  input  logic [BW-1:0]          fill_be_i,
  input  logic                   commit_i,
  input  logic [AW-1:0]          commit_addr_i,
  input  logic                   commit_long_i,
  input  logic [IW-1:0]          commit_port_i,
  input  logic [AW-LINE_LSB-1:0] hz_line_i,
  output logic                   hz_o,
  output logic                   out_valid_o,
  output logic [AW-1:0]          out_addr_o,
  output logic                   out_long_o,
  output logic [IW-1:0]          out_port_o,
  output logic [DW-1:0]          out_data_o,
  output logic [BW-1:0]          out_be_o,
  output logic                   out_last_o,
  input  logic                   out_ack_i
);
  logic [DEPTH-1:0][BEATS-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0][BEATS-1:0][BW-1:0] be_q;
  logic [DEPTH-1:0][AW-1:0]            addr_q;
  logic [DEPTH-1:0][IW-1:0]            port_q;
  logic [DEPTH-1:0]                    long_q, vld_q, hit;
  logic [DPW-1:0]                      wp_q, rp_q;
  logic [DPW:0]                        cnt_q;
  logic [BTW-1:0]                      dbeat_q;
  logic                                pop;

  assign full_o      = cnt_q == (DPW+1)'(DEPTH);
  assign out_valid_o = cnt_q != '0;
  assign out_addr_o  = addr_q[rp_q];
  assign out_long_o  = long_q[rp_q];
  assign out_port_o  = port_q[rp_q];
  assign out_data_o  = data_q[rp_q][dbeat_q];
  assign out_be_o    = be_q[rp_q][dbeat_q];
  assign out_last_o  = dbeat_q == (long_q[rp_q] ? BTW'(BEATS-1) : BTW'(BEATS/2-1));
  assign pop         = out_ack_i && out_last_o;

  for (genvar i = 0; i < DEPTH; i++) begin : g_hz
    assign hit[i] = vld_q[i] && addr_q[i][AW-1:LINE_LSB] == hz_line_i;
  end
  assign hz_o = |hit;

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      data_q[wp_q][fill_beat_i] <= fill_data_i;
      be_q[wp_q][fill_beat_i]   <= fill_be_i;
    end
    if (commit_i) begin
      addr_q[wp_q] <= commit_addr_i;
      long_q[wp_q] <= commit_long_i;
      port_q[wp_q] <= commit_port_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      dbeat_q <= '0;
      vld_q   <= '0;
    end else begin
      cnt_q <= cnt_q + (DPW+1)'(commit_i) - (DPW+1)'(pop);
      if (commit_i) begin
        vld_q[wp_q] <= 1'b1;
        wp_q        <= (wp_q == DPW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      end
      if (out_ack_i) dbeat_q <= out_last_o ? '0 : dbeat_q + 1'b1;
      if (pop) begin
        vld_q[rp_q] <= 1'b0;
        rp_q        <= (rp_q == DPW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_req_arbiter.sv
`timescale 1ns/1ps
module mem_req_arbiter
  import mem_arb_pkg::*;
#(
  parameter int N        = NPORT,
  parameter int AW       = ADDR_W,
  parameter int DW       = DATA_W,
  parameter int PW       = PRIO_W,
  parameter int DEPTH    = WB_DEPTH,
  localparam int IW      = $clog2(N),
  localparam int BW      = DW / 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         req_valid_i,
  output logic [N-1:0]         req_ready_o,
  input  logic [N-1:0]         req_write_i,
  input  logic [N-1:0]         req_long_i,
  input  logic [N-1:0][PW-1:0] req_prio_i,
  input  logic [N-1:0][AW-1:0] req_addr_i,
  input  logic [N-1:0][DW-1:0] req_wdata_i,
  input  logic [N-1:0][BW-1:0] req_be_i,
  output logic                 dn_valid_o,
  input  logic                 dn_ready_i,
  output logic                 dn_write_o,
  output logic                 dn_long_o,
  output logic [IW-1:0]        dn_port_o,
  output logic [AW-1:0]        dn_addr_o,
  output logic [DW-1:0]        dn_wdata_o,
  output logic [BW-1:0]        dn_be_o,
  output logic                 dn_last_o
);
  localparam int BEATS = LINE_B * 8 / DW;
  localparam int BTW   = $clog2(BEATS);

  logic           busy_q, gw_q, gl_q, lock_q;
  logic [IW-1:0]  gnt_q, ptr_q, win;
  logic [AW-1:0]  ga_q;
  logic [BTW-1:0] beat_q;
  logic [N-1:0]   cand;
  logic           found, wb_full, wb_hz, wb_valid, wb_last, wb_long;
  logic [AW-1:0]  wb_addr;
  logic [IW-1:0]  wb_port;
  logic [DW-1:0]  wb_data;
  logic [BW-1:0]  wb_be;
  logic           read_go, sel_read, drain_act, wr_hs, rd_hs, beat_last;

  for (genvar i = 0; i < N; i++) begin : g_port
    assign cand[i]        = req_valid_i[i] && !(req_write_i[i] && wb_full);
    assign req_ready_o[i] = busy_q && gnt_q == IW'(i) && (gw_q ? 1'b1 : rd_hs);
  end

  arb_prio_pick #(.N(N), .PW(PW), .IW(IW)) u_pick (
    .cand_i (cand),
    .prio_i (req_prio_i),
    .ptr_i  (ptr_q),
    .found_o(found),
    .win_o  (win)
  );

  assign read_go   = busy_q && !gw_q && req_valid_i[gnt_q] && !wb_hz;
  assign sel_read  = read_go && !lock_q;
  assign drain_act = !sel_read && wb_valid;
  assign rd_hs     = sel_read && dn_ready_i;
  assign wr_hs     = busy_q && gw_q && req_valid_i[gnt_q];
  assign beat_last = beat_q == (gl_q ? BTW'(BEATS-1) : BTW'(BEATS/2-1));

  arb_wr_buf #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW), .BEATS(BEATS), .LINE_LSB(LINE_LSB)
  ) u_wbuf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .full_o       (wb_full),
    .fill_en_i    (wr_hs),
    .fill_beat_i  (beat_q),
    .fill_data_i  (req_wdata_i[gnt_q]),
    .fill_be_i    (req_be_i[gnt_q]),
    .commit_i     (wr_hs && beat_last),
    .commit_addr_i(ga_q),
    .commit_long_i(gl_q),
    .commit_port_i(gnt_q),
    .hz_line_i    (ga_q[AW-1:LINE_LSB]),
    .hz_o         (wb_hz),
    .out_valid_o  (wb_valid),
    .out_addr_o   (wb_addr),
    .out_long_o   (wb_long),
    .out_port_o   (wb_port),
    .out_data_o   (wb_data),
    .out_be_o     (wb_be),
    .out_last_o   (wb_last),
    .out_ack_i    (drain_act && dn_ready_i)
  );

  assign dn_valid_o = sel_read || wb_valid;
  assign dn_write_o = !sel_read;
  assign dn_long_o  = sel_read ? gl_q  : wb_long;
  assign dn_port_o  = sel_read ? gnt_q : wb_port;
  assign dn_addr_o  = sel_read ? ga_q  : wb_addr;
  assign dn_wdata_o = sel_read ? '0    : wb_data;
  assign dn_be_o    = sel_read ? '0    : wb_be;
  assign dn_last_o  = sel_read ? 1'b1  : wb_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      gw_q   <= 1'b0;
      gl_q   <= 1'b0;
      gnt_q  <= '0;
      ptr_q  <= '0;
      ga_q   <= '0;
      beat_q <= '0;
      lock_q <= 1'b0;
    end else begin
      // a drain burst once offered keeps the channel until its last beat
      lock_q <= drain_act && !(dn_ready_i && wb_last);
      if (!busy_q) begin
        if (found) begin
          busy_q <= 1'b1;
          gnt_q  <= win;
          gw_q   <= req_write_i[win];
          gl_q   <= req_long_i[win];
          ga_q   <= req_addr_i[win];
          beat_q <= '0;
          ptr_q  <= (win == IW'(N-1)) ? '0 : win + 1'b1;
        end
      end else if (wr_hs) begin
        beat_q <= beat_q + 1'b1;
        if (beat_last) busy_q <= 1'b0;
      end else if (rd_hs) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mem_req_arbiter_chk.sv
`timescale 1ns/1ps
module mem_req_arbiter_chk #(
  parameter int N  = 7,
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int PW = 4,
  parameter int IW = 3,
  parameter int BEATS = 4,
  parameter int BTW = $clog2(BEATS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N-1:0]         req_valid_i,
  input logic [N-1:0]         req_write_i,
  input logic [N-1:0][PW-1:0] req_prio_i,
  input logic [N-1:0]         req_ready_o,
  input logic                 dn_valid_o,
  input logic                 dn_ready_i,
  input logic                 dn_write_o,
  input logic                 dn_long_o,
  input logic                 dn_last_o,
  input logic [AW-1:0]        dn_addr_o,
  input logic [DW-1:0]        dn_wdata_o,
  input logic                 busy_q,
  input logic [IW-1:0]        gnt_q,
  input logic                 wb_full,
  input logic                 wb_hz
);
  logic                 p_busy, p_full, hi;
  logic [N-1:0]         p_valid, p_write;
  logic [N-1:0][PW-1:0] p_prio;
  logic [BTW-1:0]       dcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_busy  <= 1'b0;
      p_full  <= 1'b0;
      p_valid <= '0;
      p_write <= '0;
      p_prio  <= '0;
      dcnt    <= '0;
    end else begin
      p_busy  <= busy_q;
      p_full  <= wb_full;
      p_valid <= req_valid_i;
      p_write <= req_write_i;
      p_prio  <= req_prio_i;
      if (dn_valid_o && dn_ready_i && dn_write_o) dcnt <= dn_last_o ? '0 : dcnt + 1'b1;
    end
  end

  always_comb begin
    hi = 1'b0;
    for (int i = 0; i < N; i++)
      if (p_valid[i] && !(p_write[i] && p_full) && p_prio[i] > p_prio[gnt_q]) hi = 1'b1;
  end

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o)); // R1
  AST_TOP_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !p_busy) |-> !hi); // R2
  AST_BURST_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && dn_ready_i && dn_write_o && dn_last_o) |->
      dcnt == (dn_long_o ? BTW'(BEATS-1) : BTW'(BEATS/2-1))); // R4
  AST_RAW_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && !dn_write_o) |-> !wb_hz); // R9
  AST_READ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && !dn_write_o) |-> dn_last_o); // R10
  AST_DN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && !dn_ready_i) |=> dn_valid_o && $stable(dn_addr_o)
      && $stable(dn_write_o) && $stable(dn_wdata_o)); // R11
endmodule

bind mem_req_arbiter mem_req_arbiter_chk #(
  .N(N), .AW(AW), .DW(DW), .PW(PW), .IW(IW), .BEATS(BEATS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_prio_i (req_prio_i),
  .req_ready_o(req_ready_o),
  .dn_valid_o (dn_valid_o),
  .dn_ready_i (dn_ready_i),
  .dn_write_o (dn_write_o),
  .dn_long_o  (dn_long_o),
  .dn_last_o  (dn_last_o),
  .dn_addr_o  (dn_addr_o),
  .dn_wdata_o (dn_wdata_o),
  .busy_q     (busy_q),
  .gnt_q      (gnt_q),
  .wb_full    (wb_full),
  .wb_hz      (wb_hz)
);

// File: tb/mem_req_arbiter_test.sv
`timescale 1ns/1ps
module mem_req_arbiter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [6:0]       req_valid = '0, req_ready, req_write = '0, req_long = '0;
  logic [6:0][3:0]  req_prio = '0;
  logic [6:0][31:0] req_addr = '0;
  logic [6:0][63:0] req_wdata = '0;
  logic [6:0][7:0]  req_be = '0;
  logic dn_valid, dn_ready = 1'b0, dn_write, dn_long, dn_last;
  logic [2:0]  dn_port;
  logic [31:0] dn_addr;
  logic [63:0] dn_wdata;
  logic [7:0]  dn_be;

  mem_req_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_long_i(req_long), .req_prio_i(req_prio), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_be_i(req_be),
    .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_write_o(dn_write),
    .dn_long_o(dn_long), .dn_port_o(dn_port), .dn_addr_o(dn_addr),
    .dn_wdata_o(dn_wdata), .dn_be_o(dn_be), .dn_last_o(dn_last)
  );

  int total = 0, bad = 0, mptr = 0, mode = 0;
  bit s_act[7], s_wr[7], s_long[7];
  int s_prio[7];
  logic [31:0] s_addr[7];

  function automatic logic [63:0] wpat(int p, int b);
    return 64'(p * 256 + b + 1) * 64'h9E37_79B9_7F4A_7C15;
  endfunction
  function automatic logic [7:0] bpat(int p, int b);
    return (8'hFF >> ((p + b) % 8)) ^ 8'(p * 17);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_port(input int p, input bit act, input bit wr, input bit lg,
                          input int pr, input logic [31:0] ad);
    s_act[p] = act; s_wr[p] = wr; s_long[p] = lg; s_prio[p] = pr; s_addr[p] = ad;
  endtask

  task automatic run_scn(input string nm);
    int ord[7]; int n = 0; int gi = 0; int cyc = 0; int dbeat = 0; int wdone = 0; int nwr = 0;
    bit rem[7]; bit dn[7]; int beat[7]; int cur = -1;
    int wq[$]; int rq[$];
    int v1 = 0, vh = 0, vhz = 0, vgr = 0;
    bit pv = 0, pr = 0, pw = 0; logic [31:0] pa = '0; logic [63:0] pd = '0;
    bit fin = 0;
    for (int p = 0; p < 7; p++) begin
      rem[p] = s_act[p]; dn[p] = !s_act[p]; beat[p] = 0;
      if (s_act[p] && s_wr[p]) nwr++;
    end
    // reference grant order
    while (1) begin
      int best = -1;
      for (int k = 0; k < 7; k++) begin
        int idx = (mptr + k) % 7;
        if (rem[idx] && (best < 0 || s_prio[idx] > s_prio[best])) best = idx;
      end
      if (best < 0) break;
      ord[n] = best; n++; rem[best] = 0; mptr = (best + 1) % 7;
    end
    while (!fin && cyc < 3000) begin
      @(negedge clk);
      for (int p = 0; p < 7; p++) begin
        req_valid[p] = s_act[p] && !dn[p];
        req_write[p] = s_wr[p];
        req_long[p]  = s_long[p];
        req_prio[p]  = 4'(s_prio[p]);
        req_addr[p]  = s_addr[p];
        req_wdata[p] = wpat(p, beat[p]);
        req_be[p]    = bpat(p, beat[p]);
      end
      dn_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 != 2) : (cyc >= 80);
      #1;
      if ($countones(req_ready) > 1) v1++;
      if (pv && !pr && !(dn_valid && dn_addr == pa && dn_write == pw && dn_wdata == pd)) vh++;
      pv = dn_valid; pr = dn_ready; pa = dn_addr; pw = dn_write; pd = dn_wdata;
      for (int p = 0; p < 7; p++) begin
        if (req_valid[p] && req_ready[p]) begin
          int nb = s_long[p] ? 4 : 2;
          if (cur >= 0 && cur != p) vgr++;
          if (beat[p] == 0) begin
            chk(gi < n && ord[gi] == p, "R2 R3", {nm, " grant order"}, p, gi < n ? ord[gi] : -1);
            gi++;
          end
          if (s_wr[p]) begin
            beat[p]++;
            cur = p;
            if (beat[p] == nb) begin dn[p] = 1; cur = -1; wq.push_back(p); wdone++; end
          end else begin
            foreach (wq[j]) if (s_addr[wq[j]][31:5] == s_addr[p][31:5]) vhz++;
            dn[p] = 1; rq.push_back(p);
          end
        end
      end
      if (dn_valid && dn_ready) begin
        if (dn_write) begin
          int p = wq.size() ? wq[0] : 0;
          int nb = s_long[p] ? 4 : 2;
          chk(wq.size() > 0 && dn_port == 3'(p) && dn_addr == s_addr[p], "R8",
              {nm, " drain port"}, dn_port, p);
          chk(dn_wdata == wpat(p, dbeat) && dn_be == bpat(p, dbeat), "R6",
              {nm, " write data"}, dn_wdata, wpat(p, dbeat));
          chk(dn_last == (dbeat == nb - 1), "R4", {nm, " write last"}, dn_last, dbeat == nb - 1);
          dbeat++;
          if (dbeat == nb || dn_last) begin dbeat = 0; if (wq.size()) void'(wq.pop_front()); end
        end else begin
          int p = rq.size() ? rq[0] : 0;
          chk(rq.size() > 0 && dn_port == 3'(p) && dn_addr == s_addr[p] &&
              dn_long == s_long[p] && dn_last, "R10", {nm, " read cmd"}, dn_addr, s_addr[p]);
          if (rq.size()) void'(rq.pop_front());
        end
      end
      if (mode == 2 && cyc == 79)
        chk(wdone == (nwr < 5 ? nwr : 5), "R7", {nm, " bursts held while stalled"}, wdone,
            nwr < 5 ? nwr : 5);
      fin = (wq.size() == 0 && rq.size() == 0);
      for (int p = 0; p < 7; p++) if (!dn[p]) fin = 0;
      cyc++;
    end
    chk(fin, "R5", {nm, " completion"}, cyc, 0);
    chk(gi == n, "R2", {nm, " grant count"}, gi, n);
    chk(v1 == 0, "R1", {nm, " single ready"}, v1, 0);
    chk(vgr == 0, "R5", {nm, " burst interleave"}, vgr, 0);
    chk(vhz == 0, "R9", {nm, " read over pending write"}, vhz, 0);
    chk(vh == 0, "R11", {nm, " downstream hold"}, vh, 0);
    @(negedge clk);
    req_valid = '0; dn_ready = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == '0 && !dn_valid, "R12", "in reset", {req_ready, dn_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == '0 && !dn_valid, "R12", "after reset", {req_ready, dn_valid}, 0);

    mode = 0;
    for (int p = 0; p < 7; p++) set_port(p, 1, 0, p % 2, (p * 2 + 3) % 16, 32'h1000 + p * 32);
    run_scn("distinct reads");
    mode = 1;
    for (int p = 0; p < 7; p++) set_port(p, 1, 0, 1, 7, 32'h1400 + p * 32);
    run_scn("tied reads a");
    run_scn("tied reads b");
    for (int p = 0; p < 7; p++) set_port(p, 1, 1, p % 3 == 0, ((p * 7) % 4) * 3, 32'h2000 + p * 32);
    run_scn("mixed-prio writes");
    mode = 2;
    for (int p = 0; p < 7; p++) set_port(p, 1, 1, 1, 4, 32'h3000 + p * 32);
    run_scn("buffer full");
    mode = 0;
    for (int p = 0; p < 7; p++) set_port(p, 1, p < 3, p % 2, (p % 4) * 5, 32'h4000 + p * 32);
    run_scn("reads and writes");
    mode = 2;
    for (int p = 0; p < 7; p++) set_port(p, 0, 0, 0, 0, 0);
    set_port(1, 1, 1, 1, 12, 32'h8000);
    set_port(4, 1, 0, 0, 2, 32'h8010);
    set_port(6, 1, 0, 1, 1, 32'h9000);
    run_scn("line hazard");
    for (int k = 0; k < 7; k++) begin
      mode = k % 2;
      for (int p = 0; p < 7; p++)
        set_port(p, 1, (p + k) % 2, (p + k) % 3 == 0, p == k ? 15 : (p + k) % 3,
                 32'h5000 + k * 32'h400 + p * 32);
      run_scn($sformatf("sweep top=%0d", k));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule